// File: doc/BRIEF.md
# Periodic Conversion Trigger Timer

This block generates start-of-conversion trigger pulses for a queued analog-to-digital converter sequencer. A counter advances on each cycle where the prescaled conversion-clock enable is high. When it reaches a terminal count set by a 4-bit period code, it wraps to zero and issues a single-cycle trigger. In periodic mode it keeps retriggering. In interval mode it fires once and then waits until software writes the mode again.

The block's main concern is the debug freeze input. If freeze is raised while the sequencer reports a conversion in progress, the timer keeps its count running but issues no trigger. It clears the count only once that conversion has finished. If freeze is raised while no conversion is busy, the count goes to zero on the next clock edge and stays there. When freeze is released, counting starts again from zero.

Top module: `conv_trig_timer`

## Requirements
- R1: A synchronous active-high reset clears the count, the trigger output and any pending freeze. After reset is released, counting starts from zero.
- R2: Mode code 2'b00 (off) and the reserved code 2'b11 hold the count at zero and never produce a trigger.
- R3: The count changes only on cycles where the tick enable is high. On other cycles it holds, unless it is being forced to zero.
- R4: The terminal count is 2^(code+BASE_EXP) ticks. The count runs from 0 to that value minus one and then wraps to 0. At the same edge the trigger goes high for exactly one cycle. In periodic mode (2'b01) with the tick always high, the first trigger appears TC+1 edges after the mode write, and later triggers follow every TC edges.
- R5: In interval mode (2'b10) the block issues one trigger after the period. After that the count holds at zero with no further triggers until the mode input changes to interval from another value.
- R6: If freeze is high while busy is low, the count is zero after the next edge. It stays at zero, with no trigger, for as long as freeze stays high.
- R7: After freeze is released, the count restarts from zero. The next trigger comes TC ticks after the release.
- R8: If freeze is raised while busy is high, the count keeps advancing on ticks (wrapping at the terminal count) until busy falls. The count is zero after the edge at which busy is seen low. This happens even if freeze was dropped in the meantime.
- R9: No trigger is issued while freeze is high or while a freeze is pending behind a busy conversion.
- R10: Any change of the mode input restarts the count at zero on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Prescaled conversion-clock enable |
| mode | input | 2 | 00 off, 01 periodic, 10 interval, 11 off |
| period_code | input | CODE_W | Period select, terminal count 2^(code+BASE_EXP) |
| freeze | input | 1 | Debug freeze request |
| busy | input | 1 | Triggered conversion in progress |
| trig | output | 1 | Single-cycle conversion trigger |
| count | output | CNT_W | Current timer count |

## Verification
The bench builds the block with CODE_W=3 and BASE_EXP=1. This shrinks the terminal counts to the range 2 to 256 ticks, so every period code can be swept for several full periods in both trigger modes. The small periods also allow the count to wrap while a freeze is held pending behind a busy conversion. This makes the suppression of the wrap trigger observable, together with the later clear on busy release and the restart from zero after freeze.

// File: rtl/ctt_pkg.sv
package ctt_pkg;

    typedef enum logic [1:0] {
        MODE_OFF      = 2'b00,
        MODE_PERIODIC = 2'b01,
        MODE_INTERVAL = 2'b10,
        MODE_RSVD     = 2'b11
    } ctt_mode_e;

    // Freeze decision handed from the freeze controller to the counter
    typedef struct packed {
        logic hold_zero;   // force count to zero, no trigger
        logic quiet;       // keep counting, suppress trigger
    } ctt_frz_t;

    function automatic logic mode_runs(input ctt_mode_e m);
        return (m == MODE_PERIODIC) || (m == MODE_INTERVAL);
    endfunction

endpackage

// File: rtl/ctt_tc_decode.sv
module ctt_tc_decode #(
    parameter int CODE_W   = 4,
    parameter int BASE_EXP = 7,
    parameter int CNT_W    = BASE_EXP + (2**CODE_W) - 1
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  last_val
);
    localparam int NCODE = 2**CODE_W;

    logic [CNT_W-1:0] masks [NCODE];

    for (genvar g = 0; g < NCODE; g++) begin : g_mask
        localparam int EXP = g + BASE_EXP;
        assign masks[g] = {CNT_W{1'b1}} >> (CNT_W - EXP);
    end

    assign last_val = masks[code];

endmodule

// File: rtl/ctt_freeze_ctl.sv
module ctt_freeze_ctl
    import ctt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  logic     freeze,
    input  logic     busy,
    output logic     pend,
    output ctt_frz_t ctl
);
    logic stop_req;

    assign stop_req      = freeze || pend;
    assign ctl.hold_zero = run && stop_req && !busy;
    assign ctl.quiet     = run && stop_req && busy;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pend <= 1'b0;
        end else begin
            pend <= stop_req && busy;
        end
    end

    // R8
    pend_needs_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (pend && !busy) |=> !pend);

endmodule

// File: rtl/ctt_counter.sv
module ctt_counter
    import ctt_pkg::*;
#(
    parameter int CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic             periodic,
    input  logic             restart,
    input  logic [CNT_W-1:0] last_val,
    input  ctt_frz_t         ctl,
    output logic [CNT_W-1:0] cnt,
    output logic             trig
);
    logic             done;
    logic             at_last;
    logic [CNT_W-1:0] cnt_inc;

    assign at_last = (cnt == last_val);
    assign cnt_inc = at_last ? '0 : cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            trig <= 1'b0;
            done <= 1'b0;
        end else begin
            trig <= 1'b0;
            if (!run || restart) begin
                cnt  <= '0;
                done <= 1'b0;
            end else if (ctl.hold_zero) begin
                cnt <= '0;
            end else if (ctl.quiet) begin
                if (tick) cnt <= cnt_inc;
            end else if (done) begin
                cnt <= '0;
            end else if (tick) begin
                cnt <= cnt_inc;
                if (at_last) begin
                    trig <= 1'b1;
                    if (!periodic) done <= 1'b1;
                end
            end
        end
    end

    // R4
    trig_single_chk: assert property (@(posedge clk) disable iff (rst)
        trig |=> !trig);
    // R4
    trig_at_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        trig |-> (cnt == '0));
    // R5
    interval_once_chk: assert property (@(posedge clk) disable iff (rst)
        (done && run && !restart) |=> !trig);

endmodule

// File: rtl/conv_trig_timer.sv
module conv_trig_timer
    import ctt_pkg::*;
#(
    parameter int CODE_W   = 4,
    parameter int BASE_EXP = 7,
    parameter int CNT_W    = BASE_EXP + (2**CODE_W) - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [1:0]        mode,
    input  logic [CODE_W-1:0] period_code,
    input  logic              freeze,
    input  logic              busy,
    output logic              trig,
    output logic [CNT_W-1:0]  count
);
    ctt_mode_e        mode_e;
    logic [1:0]       mode_q;
    logic             run;
    logic             restart;
    logic             pend;
    ctt_frz_t         frz;
    logic [CNT_W-1:0] last_val;

    assign mode_e  = ctt_mode_e'(mode);
    assign run     = mode_runs(mode_e);
    assign restart = (mode != mode_q);

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_OFF;
        else     mode_q <= mode;
    end

    ctt_tc_decode #(
        .CODE_W  (CODE_W),
        .BASE_EXP(BASE_EXP),
        .CNT_W   (CNT_W)
    ) u_dec (
        .code    (period_code),
        .last_val(last_val)
    );

    ctt_freeze_ctl u_frz (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .freeze(freeze),
        .busy  (busy),
        .pend  (pend),
        .ctl   (frz)
    );

    ctt_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .run     (run),
        .periodic(mode_e == MODE_PERIODIC),
        .restart (restart),
        .last_val(last_val),
        .ctl     (frz),
        .cnt     (count),
        .trig    (trig)
    );

    // R2
    off_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (count == '0) && !trig);
    // R3
    tick_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> (count == $past(count)) || (count == '0));
    // R6
    freeze_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (freeze && !busy) |=> (count == '0));
    // R9
    no_trig_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (freeze || pend) |=> !trig);
    // R8
    pend_release_chk: assert property (@(posedge clk) disable iff (rst)
        (pend && !busy) |=> (count == '0));
    // R10
    mode_restart_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> (count == '0));

endmodule

// File: tb/tb_conv_trig_timer.sv
module tb_conv_trig_timer;
    localparam int CODE_W   = 3;
    localparam int BASE_EXP = 1;
    localparam int CNT_W    = BASE_EXP + (2**CODE_W) - 1;

    logic              clk = 1'b0;
    logic              rst;
    logic              tick;
    logic [1:0]        mode;
    logic [CODE_W-1:0] period_code;
    logic              freeze;
    logic              busy;
    logic              trig;
    logic [CNT_W-1:0]  count;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    conv_trig_timer #(.CODE_W(CODE_W), .BASE_EXP(BASE_EXP)) dut (
        .clk(clk), .rst(rst), .tick(tick), .mode(mode),
        .period_code(period_code), .freeze(freeze), .busy(busy),
        .trig(trig), .count(count)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic int tcof(input int code);
        return 1 << (code + BASE_EXP);
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int tc;
        int c0;
        int last_t;
        int gap;
        rst = 1'b1; tick = 1'b1; mode = 2'b00; period_code = '0;
        freeze = 1'b0; busy = 1'b0;
        repeat (3) step();
        chk(count == 0, "R1 reset count", count, 0);
        chk(trig == 0, "R1 reset trig", trig, 0);
        rst = 1'b0;

        // R2: off and reserved modes stay idle
        for (int m = 0; m < 2; m++) begin
            mode = (m == 0) ? 2'b00 : 2'b11;
            period_code = 0;
            for (int k = 0; k < 20; k++) begin
                step();
                chk(count == 0 && trig == 0, "R2 idle", count, 0);
            end
        end

        // R4: periodic sweep over every period code
        for (int code = 0; code < 2**CODE_W; code++) begin
            mode = 2'b00; step(); step();
            tc = tcof(code);
            period_code = code[CODE_W-1:0];
            mode = 2'b01;
            for (int k = 1; k <= 3*tc + 1; k++) begin
                step();
                chk(trig == (((k - 1) % tc == 0) && k > 1),
                    "R4 periodic trig", trig, ((k - 1) % tc == 0) && k > 1);
                chk(count == (k - 1) % tc, "R4 periodic count", count, (k - 1) % tc);
            end
        end

        // R3: tick every third cycle, code 2 -> trigger gap 3*8
        mode = 2'b00; step();
        period_code = 3'd2; mode = 2'b01;
        last_t = -1; gap = 0;
        for (int k = 1; k <= 80; k++) begin
            tick = (k % 3 == 0);
            c0 = count;
            step();
            if (!tick) chk(count == c0 || count == 0, "R3 hold", count, c0);
            if (trig) begin
                if (last_t >= 0) gap = k - last_t;
                last_t = k;
            end
        end
        chk(gap == 24, "R3 gated period", gap, 24);
        tick = 1'b1;

        // R5: interval mode, code 1 -> TC 4
        mode = 2'b00; step();
        period_code = 3'd1; mode = 2'b10;
        for (int k = 1; k <= 30; k++) begin
            step();
            chk(trig == (k == 5), "R5 interval trig", trig, k == 5);
            if (k > 5) chk(count == 0, "R5 interval hold", count, 0);
        end
        mode = 2'b01; step(); mode = 2'b10;
        for (int k = 1; k <= 12; k++) begin
            step();
            chk(trig == (k == 5), "R5 rearm trig", trig, k == 5);
        end

        // R6/R7: freeze with no conversion busy, code 3 -> TC 16
        mode = 2'b00; step();
        period_code = 3'd3; mode = 2'b01; tc = 16;
        repeat (6) step();
        chk(count == 5, "R10 restart base", count, 5);
        freeze = 1'b1;
        for (int k = 0; k < 12; k++) begin
            step();
            chk(count == 0 && trig == 0, "R6 frozen", count, 0);
        end
        freeze = 1'b0;
        for (int j = 1; j <= tc; j++) begin
            step();
            chk(count == j % tc, "R7 restart count", count, j % tc);
            chk(trig == (j == tc), "R7 restart trig", trig, j == tc);
        end

        // R8/R9: freeze behind busy conversion, code 0 -> TC 2
        mode = 2'b00; step();
        period_code = 3'd0; mode = 2'b01; tc = 2;
        repeat (3) step();
        busy = 1'b1; freeze = 1'b1;
        c0 = count;
        for (int j = 1; j <= 9; j++) begin
            if (j == 7) freeze = 1'b0;
            step();
            chk(trig == 0, "R9 no trig pending", trig, 0);
            chk(count == (c0 + j) % tc, "R8 busy advance", count, (c0 + j) % tc);
        end
        busy = 1'b0;
        step();
        chk(count == 0, "R8 clear after busy", count, 0);
        step();
        chk(count == 1, "R8 resume", count, 1);

        // R10: mode change mid-count restarts
        mode = 2'b00; step();
        period_code = 3'd3; mode = 2'b01;
        repeat (7) step();
        mode = 2'b10; step();
        chk(count == 0, "R10 mode change", count, 0);
        step();
        chk(count == 1, "R10 counts on", count, 1);

        // R1: reset mid-run with a pending freeze
        busy = 1'b1; freeze = 1'b1; step();
        rst = 1'b1; step();
        chk(count == 0 && trig == 0, "R1 mid reset", count, 0);
        rst = 1'b0; freeze = 1'b0; busy = 1'b0; step();
        chk(count == 0, "R1 after reset", count, 0);
        step();
        chk(count == 1, "R1 no stale pend", count, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule